// File: doc/BRIEF.md
# SMBus Alert Line and Alert-Response Responder

This block owns a device's shared, active-low alert line and answers the host when the host asks who raised it. A fault input sets an internal alert latch. While the latch is set and no response has completed, the block pulls the open-drain alert line low. When the host reads from the alert response address (seven bits 0001100, R/W bit = 1), the block acknowledges the query. It then returns its own 7-bit device address as the data byte. Several devices may answer the same query on the wired-AND data line. Each one compares the line with what it sends, so the device with the lowest address ends up on the bus.

A device that wins and completes the byte lets go of the alert line. It keeps the latch until a status-read strobe arrives while the fault input is low. A device that loses arbitration keeps pulling the alert line, so a later query can find it. The bus inputs are taken as already synchronised to `clk`. Both outputs are pull-low enables for external open-drain pads.

Top module: `ara_alert_responder`

## Requirements
- R1: After reset, both pull outputs (`alert_pull`, `sda_pull`) are 0.
- R2: A cycle with `cond_active` = 1 sets the alert latch, and `alert_pull` is 1 from the next cycle. It stays 1 after `cond_active` returns to 0.
- R3: A byte of address 0001100 followed by R/W = 1 (read), received while `alert_pull` = 1, is acknowledged. The block pulls SDA low through the ninth SCL pulse.
- R4: There is no acknowledge for any other address, for a write (R/W = 0) to 0001100, or for a read when `alert_pull` = 0.
- R5: After the acknowledge, the block sends the byte {dev_addr[6:0], 1} MSB first. It pulls SDA for each 0 bit, and each bit changes only while SCL is low.
- R6: If the block releases SDA for a 1 bit and samples 0 at the rising SCL edge, it drives nothing for the rest of that byte and `alert_pull` stays 1. With a competitor on the line, the host therefore reads the smaller of the two bytes.
- R7: If the block sends all eight bits without losing and the ninth (host acknowledge) SCL rising edge passes, `alert_pull` goes to 0.
- R8: A `status_rd` pulse with `cond_active` = 0 clears the latch. A `status_rd` pulse with `cond_active` = 1 has no effect.
- R9: A START, including a repeated START in mid-byte, restarts address reception. After a STOP, `sda_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired-AND bus value) |
| dev_addr | input | 7 | This device's own bus address |
| cond_active | input | 1 | Fault condition currently present |
| status_rd | input | 1 | One-cycle strobe: status registers were read |
| sda_pull | output | 1 | 1 = pull SDA low |
| alert_pull | output | 1 | 1 = pull the active-low alert line low |

## Verification
The bench goes after arbitration against a modelled competitor with a random address. If the loss check were missing, the bus would carry the AND of the two bytes instead of the smaller one. A design that cleared the alert on a loss would leave the loser silent. Write queries, foreign addresses and queries with the alert released must see no acknowledge, or the block would answer queries that are not its own. Status reads taken while the fault persists, and a repeated START in mid-byte, cover the wrong clearing and stale bit counters a faulty design would show.

// File: rtl/ara_pkg.sv
package ara_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK0,
    ST_ACK1,
    ST_TX,
    ST_HACK,
    ST_WAIT
  } ara_state_e;
endpackage

// File: rtl/ara_bus_events.sv
module ara_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_q && scl_i && sda_q && !sda_i;
    stop_o  = scl_q && scl_i && !sda_q && sda_i;
    rise_o  = !scl_q && scl_i;
    fall_o  = scl_q && !scl_i;
  end
endmodule

// File: rtl/ara_alert_latch.sv
module ara_alert_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_active,
  input  logic status_rd,
  input  logic win_done,
  output logic latched_o,
  output logic alert_pull_o
);
  logic lat_q, lat_n, ans_q, ans_n;

  always_comb begin
    lat_n = lat_q;
    ans_n = ans_q;
    if (cond_active) lat_n = 1'b1;
    if (win_done)    ans_n = 1'b1;
    if (status_rd && !cond_active) begin
      lat_n = 1'b0;
      ans_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      ans_q <= 1'b0;
    end else begin
      lat_q <= lat_n;
      ans_q <= ans_n;
    end
  end

  assign latched_o    = lat_q;
  assign alert_pull_o = lat_q && !ans_q;
endmodule

// File: rtl/ara_resp_fsm.sv
module ara_resp_fsm
  import ara_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              alert_on_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_pull_o,
  output logic              win_done_o
);
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  ara_state_e        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              drv_q, drv_n, lost_q, lost_n;

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    drv_n      = drv_q;
    lost_n     = lost_q;
    win_done_o = 1'b0;
    if (stop_i) begin
      st_n  = ST_IDLE;
      drv_n = 1'b0;
    end else if (start_i) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      drv_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (rise_i) begin
          sh_n  = {sh_q[BYTE_W-2:0], sda_i};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT)
            st_n = (sh_q[ADDR_W-1:0] == ARA_ADDR && sda_i && alert_on_i) ? ST_ACK0 : ST_WAIT;
        end
        ST_ACK0: if (fall_i) begin
          drv_n = 1'b1;
          st_n  = ST_ACK1;
        end
        ST_ACK1: if (fall_i) begin
          sh_n   = {dev_addr_i, 1'b1};
          drv_n  = !dev_addr_i[ADDR_W-1];
          cnt_n  = '0;
          lost_n = 1'b0;
          st_n   = ST_TX;
        end
        ST_TX: begin
          if (rise_i) begin
            cnt_n = cnt_q + 1'b1;
            if (!drv_q && !sda_i) lost_n = 1'b1;
          end else if (fall_i) begin
            if (cnt_q == FULL) begin
              drv_n = 1'b0;
              st_n  = ST_HACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              drv_n = !lost_q && !sh_q[BYTE_W-2];
            end
          end
        end
        ST_HACK: if (rise_i) begin
          win_done_o = !lost_q;
          st_n       = ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      drv_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      drv_q  <= drv_n;
      lost_q <= lost_n;
    end
  end

  assign sda_pull_o = drv_q;
endmodule

// File: rtl/ara_alert_responder.sv
module ara_alert_responder #(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              cond_active,
  input  logic              status_rd,
  output logic              sda_pull,
  output logic              alert_pull
);
  logic ev_start, ev_stop, ev_rise, ev_fall;
  logic win_done, latched;

  ara_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall)
  );

  ara_alert_latch u_lat (
    .clk(clk), .rst_n(rst_n), .cond_active(cond_active), .status_rd(status_rd),
    .win_done(win_done), .latched_o(latched), .alert_pull_o(alert_pull)
  );

  ara_resp_fsm #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(ev_start), .stop_i(ev_stop),
    .rise_i(ev_rise), .fall_i(ev_fall), .sda_i(sda_i), .alert_on_i(alert_pull),
    .dev_addr_i(dev_addr), .sda_pull_o(sda_pull), .win_done_o(win_done)
  );
endmodule

// File: rtl/ara_alert_checker.sv
module ara_alert_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic cond_active,
  input logic status_rd,
  input logic sda_pull,
  input logic alert_pull,
  input logic win_done,
  input logic latched
);
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_pull) |-> $past(cond_active));

  p_hold_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_active |=> latched);

  p_bit_change_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_i));

  p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull) |-> ($past(win_done) || $past(status_rd && !cond_active)));

  p_keep_when_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && cond_active) |=> latched);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !sda_pull);
endmodule

bind ara_alert_responder ara_alert_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .cond_active(cond_active), .status_rd(status_rd), .sda_pull(sda_pull),
  .alert_pull(alert_pull), .win_done(win_done), .latched(latched)
);

// File: tb/tb_ara_alert_responder.sv
module tb_ara_alert_responder;
  localparam logic [6:0] ARA = 7'b0001100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, host_sda, comp_pull, cond_active, status_rd;
  logic [6:0] dev_addr;
  logic sda_pull, alert_pull, sda_bus;
  assign sda_bus = host_sda & ~sda_pull & ~comp_pull;

  ara_alert_responder dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .dev_addr(dev_addr),
    .cond_active(cond_active), .status_rd(status_rd),
    .sda_pull(sda_pull), .alert_pull(alert_pull)
  );

  int errs = 0, checks = 0;
  bit exp_lat = 0, exp_ans = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 0; w(2); host_sda = 1; w(2); scl = 1; w(3); host_sda = 0; w(3);
  endtask

  task automatic bus_stop();
    scl = 0; w(2); host_sda = 0; comp_pull = 0; w(2); scl = 1; w(3); host_sda = 1; w(3);
  endtask

  task automatic bus_bit(input bit hb, input bit cp, output bit seen, output bit dp);
    scl = 0; w(2); host_sda = hb; comp_pull = cp; w(3); scl = 1; w(2);
    seen = sda_bus; dp = sda_pull; w(2);
  endtask

  task automatic ara_txn(input logic [6:0] a, input bit rw, input bit comp_en,
                         input logic [6:0] ca, output bit dack, output logic [7:0] rd);
    bit seen, dp, clost;
    logic [7:0] cb;
    bus_start();
    for (int i = 7; i >= 0; i--) bus_bit((i == 0) ? rw : a[i-1], 1'b0, seen, dp);
    bus_bit(1'b1, comp_en, seen, dack);
    cb = {ca, 1'b1};
    clost = 0;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, comp_en && !clost && !cb[i], seen, dp);
      rd[i] = seen;
      if (comp_en && !clost && cb[i] && !seen) clost = 1;
    end
    bus_bit(1'b1, 1'b0, seen, dp);
    bus_stop();
    w(2);
  endtask

  function automatic logic [7:0] exp_read(bit resp, bit comp_en, logic [6:0] d, logic [6:0] c);
    logic [7:0] db, cb;
    db = {d, 1'b1};
    cb = {c, 1'b1};
    if (resp && comp_en) return (db < cb) ? db : cb;
    if (resp) return db;
    if (comp_en) return cb;
    return 8'hFF;
  endfunction

  task automatic pulse_cond();
    cond_active = 1; w(1); cond_active = 0; w(1);
    exp_lat = 1;
  endtask

  task automatic pulse_status();
    status_rd = 1; w(1); status_rd = 0; w(1);
    if (!cond_active) begin exp_lat = 0; exp_ans = 0; end
  endtask

  task automatic run_case(input logic [6:0] a, input bit rw, input bit comp_en,
                          input logic [6:0] ca, input string tag);
    bit resp, dack;
    logic [7:0] rd, er;
    resp = exp_lat && !exp_ans && a == ARA && rw;
    ara_txn(a, rw, comp_en, ca, dack, rd);
    chk(dack == resp, resp ? {tag, " R3 ack"} : {tag, " R4 no-ack"}, dack, resp);
    er = exp_read(resp, comp_en, dev_addr, ca);
    chk(rd == er, comp_en ? {tag, " R6 data"} : {tag, " R5 data"}, rd, er);
    if (resp && (!comp_en || {dev_addr, 1'b1} < {ca, 1'b1})) exp_ans = 1;
    chk(alert_pull == (exp_lat && !exp_ans), {tag, " R7/R6 alert"}, alert_pull, exp_lat && !exp_ans);
    chk(sda_pull == 0, {tag, " R9 released after stop"}, sda_pull, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit seen, dp, dack;
    logic [7:0] rd;
    logic [6:0] a, ca;
    bit rw, ce;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; scl = 1; host_sda = 1; comp_pull = 0; cond_active = 0; status_rd = 0;
    dev_addr = 7'h2A;
    w(4);
    chk(alert_pull == 0 && sda_pull == 0, "R1 reset", {alert_pull, sda_pull}, 0);
    rst_n = 1; w(3);
    chk(alert_pull == 0 && sda_pull == 0, "R1 after release", {alert_pull, sda_pull}, 0);

    // R2: latch and hold
    cond_active = 1; w(3); cond_active = 0; w(3); exp_lat = 1;
    chk(alert_pull == 1, "R2 latched", alert_pull, 1);
    // R8: status read while fault persists has no effect
    cond_active = 1; w(1); status_rd = 1; w(1); status_rd = 0; cond_active = 0; w(2);
    chk(alert_pull == 1, "R8 no clear while active", alert_pull, 1);

    // R4: write to ARA, foreign read
    run_case(ARA, 1'b0, 1'b0, 7'h00, "write-ara");
    run_case(7'h0D, 1'b1, 1'b0, 7'h00, "other-addr");
    // R3/R5/R7: lone responder
    run_case(ARA, 1'b1, 1'b0, 7'h00, "solo");
    chk(alert_pull == 0, "R7 released after win", alert_pull, 0);
    // R4: no alert -> no ack
    run_case(ARA, 1'b1, 1'b0, 7'h00, "answered");
    pulse_status();
    chk(alert_pull == 0, "R8 cleared", alert_pull, 0);
    run_case(ARA, 1'b1, 1'b0, 7'h00, "idle-alert");

    // R6: lower competitor wins
    pulse_cond();
    run_case(ARA, 1'b1, 1'b1, 7'h15, "lose");
    chk(alert_pull == 1, "R6 loser keeps alert", alert_pull, 1);
    // R6: higher competitor loses to DUT
    run_case(ARA, 1'b1, 1'b1, 7'h40, "win");

    // R9: repeated start in mid-byte
    pulse_status(); pulse_cond();
    bus_start();
    bus_bit(1'b0, 1'b0, seen, dp); bus_bit(1'b1, 1'b0, seen, dp); bus_bit(1'b1, 1'b0, seen, dp);
    ara_txn(ARA, 1'b1, 1'b0, 7'h00, dack, rd);
    chk(dack == 1, "R9 repeated start ack", dack, 1);
    chk(rd == {dev_addr, 1'b1}, "R9 R5 data after restart", rd, {dev_addr, 1'b1});
    exp_ans = 1;

    // random mix
    for (int it = 0; it < 60; it++) begin
      dev_addr = 7'($urandom);
      if ($urandom % 2) pulse_cond();
      if ($urandom % 4 != 0) begin a = ARA; rw = 1; end
      else begin a = 7'($urandom); rw = 1'($urandom); end
      ce = (a == ARA && rw) ? 1'($urandom) : 1'b0;
      ca = 7'($urandom);
      if (ca == dev_addr) ca = ca ^ 7'h01;
      run_case(a, rw, ce, ca, "rand");
      if ($urandom % 3 == 0) begin
        pulse_status();
        chk(alert_pull == (exp_lat && !exp_ans), "R8 rand status", alert_pull, exp_lat && !exp_ans);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule